// File: doc/BRIEF.md
# Self-Repairing Cascaded Magnitude Comparator

This block compares two unsigned operands of `WIDTH` bits and raises exactly one of three result flags: equal, greater or less. The comparison is a ripple chain of one-bit cells. Each cell takes one bit of each operand plus the three flags from the stage below it. If its own two bits differ, it overrides the incoming flags. The chain starts at the least significant bit from a fixed seed that says "equal". Cells are grouped into granules of `GRAN` bits. One extra physical granule sits above the top active one, so the array has `WIDTH/GRAN + 1` physical granules.

A steering layer maps the logical granules onto the physical ones around a single out-of-service position, called the bypass index. It routes both the operand slices and the 3-bit flag bundles that cross granule boundaries. The out-of-service granule is not idle: an online sequencer feeds it walking test vectors, drives its operand bits and its incoming flags, and checks its outgoing flags against a reference magnitude comparison. A clean pass of `GRAN*12` vectors moves the bypass index one granule down, so operation passes to the granule just tested. After granule 0 the index wraps back to the spare. A mismatch freezes the index on that granule for good. Normal comparisons continue all the while, with no stall.

A `defect_inj` input forces a stuck-at-1 defect into a chosen physical granule so that the repair path can be exercised.

Top module: `cmp_repair_top`

## Requirements
- R1: With no defect injected, `gt_o` is high exactly when `x_i > y_i` (unsigned) and `lt_o` exactly when `x_i < y_i`, valid in the same cycle the operands are applied.
- R2: Exactly one of `eq_o`, `gt_o`, `lt_o` is high in every cycle out of reset.
- R3: Reset puts the bypass index on the spare (the highest physical granule) and clears any retirement, so comparisons are correct from the first cycle after reset.
- R4: Each test visit lasts `GRAN*12` cycles. After a clean visit the bypass index moves to the next lower physical granule, and from granule 0 it wraps to the spare. The index changes at no other time, and results stay correct across every move.
- R5: A defect in the spare granule is detected on its first visit and the spare is retired. Comparisons stay correct afterwards.
- R6: A defect in an active granule is detected and that granule retired within one full rotation, `(WIDTH/GRAN+1)*GRAN*12` cycles. Comparisons are correct afterwards.
- R7: Once a granule is retired, the bypass index never changes again and the results stay correct indefinitely.
- R8: Equal operands, including all-zero and all-one, give `eq_o` = 1 through the seed flag of equal = 1, greater = 0, less = 0 at the least significant end.
- R9: Bit p of `defect_inj` forces the operand-x line of the lowest bit cell of physical granule p to 1. While that granule is in service, the defect is visible at the outputs.
- R10: A defect in physical granule 0, the seed end, is retired like any other, and comparisons are correct afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| x_i | input | WIDTH | First operand |
| y_i | input | WIDTH | Second operand |
| defect_inj | input | WIDTH/GRAN+1 | Per physical granule: stuck-at-1 on its lowest x operand line |
| eq_o | output | 1 | Operands equal |
| gt_o | output | 1 | x_i greater than y_i |
| lt_o | output | 1 | x_i less than y_i |

## Verification
The three result flags are combinational from the operands and the registered bypass index, so each result is due in the same cycle its operands are driven. The bench drives operands on the falling edge and samples one nanosecond later, which is before the next rising edge can move the bypass index.

Repair results are due one rotation after reset at the latest, or `9*96` cycles with the defaults. The bench therefore waits 1200 cycles before it expects corrected results. It checks again several thousand cycles later to confirm the retirement holds.

The visible effect of a defect (R9) is sampled in the first cycle after reset. At that point only the spare is out of service, so a defect in any other granule is still in service.

// File: rtl/cmp_repair_pkg.sv
package cmp_repair_pkg;

  typedef struct packed {
    logic eq;
    logic gt;
    logic lt;
  } cflag_t;

  localparam cflag_t FLAG_EQ = '{eq: 1'b1, gt: 1'b0, lt: 1'b0};
  localparam cflag_t FLAG_GT = '{eq: 1'b0, gt: 1'b1, lt: 1'b0};
  localparam cflag_t FLAG_LT = '{eq: 1'b0, gt: 1'b0, lt: 1'b1};

  // One ripple stage: differing bits override the flags from below.
  function automatic cflag_t cell_step(input logic xb, input logic yb, input cflag_t c);
    if (xb && !yb) return FLAG_GT;
    else if (!xb && yb) return FLAG_LT;
    else return c;
  endfunction

endpackage

// File: rtl/cmp_gran.sv
module cmp_gran
  import cmp_repair_pkg::*;
#(
  parameter int GRAN = 8
) (
  input  logic [GRAN-1:0] xa,
  input  logic [GRAN-1:0] ya,
  input  cflag_t          cin,
  output cflag_t          cout
);

  cflag_t [GRAN:0] chain;

  assign chain[0] = cin;

  for (genvar i = 0; i < GRAN; i++) begin : g_cell
    assign chain[i+1] = cell_step(xa[i], ya[i], chain[i]);
  end

  assign cout = chain[GRAN];

endmodule

// File: rtl/cmp_steer.sv
module cmp_steer
  import cmp_repair_pkg::*;
#(
  parameter  int GRAN = 8,
  parameter  int NG   = 8,
  localparam int NP   = NG + 1,
  localparam int BW   = $clog2(NP)
) (
  input  logic [NG*GRAN-1:0] x,
  input  logic [NG*GRAN-1:0] y,
  input  logic [BW-1:0]      byp,
  input  logic [GRAN-1:0]    tx,
  input  logic [GRAN-1:0]    ty,
  input  cflag_t             tcin,
  input  cflag_t [NP-1:0]    gcout,
  output logic [NP*GRAN-1:0] gx,
  output logic [NP*GRAN-1:0] gy,
  output cflag_t [NP-1:0]    gcin,
  output cflag_t             fin,
  output cflag_t             tout
);

  for (genvar p = 0; p < NP; p++) begin : g_phys
    localparam logic [BW-1:0] PI = BW'(p);

    // operand slices: below the bypass keep logical p, above it take logical p-1
    if (p == 0) begin : g_op_lo
      assign gx[p*GRAN +: GRAN] = (byp == PI) ? tx : x[p*GRAN +: GRAN];
      assign gy[p*GRAN +: GRAN] = (byp == PI) ? ty : y[p*GRAN +: GRAN];
    end else if (p == NP-1) begin : g_op_spare
      assign gx[p*GRAN +: GRAN] = (byp == PI) ? tx : x[(p-1)*GRAN +: GRAN];
      assign gy[p*GRAN +: GRAN] = (byp == PI) ? ty : y[(p-1)*GRAN +: GRAN];
    end else begin : g_op_mid
      assign gx[p*GRAN +: GRAN] = (byp == PI) ? tx :
                                  (byp > PI)  ? x[p*GRAN +: GRAN] : x[(p-1)*GRAN +: GRAN];
      assign gy[p*GRAN +: GRAN] = (byp == PI) ? ty :
                                  (byp > PI)  ? y[p*GRAN +: GRAN] : y[(p-1)*GRAN +: GRAN];
    end

    // cascade flags: skip over the bypassed neighbour with a 3-bit 2:1 choice
    if (p == 0) begin : g_cin_seed
      assign gcin[p] = (byp == PI) ? tcin : FLAG_EQ;
    end else if (p == 1) begin : g_cin_one
      assign gcin[p] = (byp == PI) ? tcin :
                       (byp == 0)  ? FLAG_EQ : gcout[0];
    end else begin : g_cin_mid
      assign gcin[p] = (byp == PI)           ? tcin :
                       (byp == BW'(p - 1))   ? gcout[p-2] : gcout[p-1];
    end
  end

  assign fin  = (byp == BW'(NP-1)) ? gcout[NP-2] : gcout[NP-1];
  assign tout = gcout[byp];

endmodule

// File: rtl/cmp_test_seq.sv
module cmp_test_seq
  import cmp_repair_pkg::*;
#(
  parameter  int GRAN = 8,
  parameter  int NP   = 9,
  localparam int NVEC = GRAN * 12,
  localparam int VW   = $clog2(NVEC),
  localparam int BW   = $clog2(NP)
) (
  input  logic            clk,
  input  logic            rst,
  input  cflag_t          tout,
  output logic [BW-1:0]   byp,
  output logic [GRAN-1:0] tx,
  output logic [GRAN-1:0] ty,
  output cflag_t          tcin,
  output logic            mismatch,
  output logic            wrap,
  output logic            retired
);

  logic [VW-1:0] vec;
  logic [1:0]    pair;
  cflag_t        expv;

  // vector index -> (bit position, operand pair, incoming flag choice)
  function automatic int pos_of(input logic [VW-1:0] v);
    return int'(v) / 12;
  endfunction

  function automatic logic [1:0] pair_of(input logic [VW-1:0] v);
    return 2'((int'(v) / 3) % 4);
  endfunction

  function automatic cflag_t cin_of(input logic [VW-1:0] v);
    case (int'(v) % 3)
      0:       return FLAG_EQ;
      1:       return FLAG_GT;
      default: return FLAG_LT;
    endcase
  endfunction

  // zeros below the position, the chosen bit at it, ones above it
  function automatic logic [GRAN-1:0] pattern(input logic [VW-1:0] v, input logic b);
    logic [GRAN-1:0] r;
    for (int i = 0; i < GRAN; i++) begin
      if (i < pos_of(v))       r[i] = 1'b0;
      else if (i == pos_of(v)) r[i] = b;
      else                     r[i] = 1'b1;
    end
    return r;
  endfunction

  function automatic cflag_t gran_ref(input logic [GRAN-1:0] a, input logic [GRAN-1:0] b,
                                      input cflag_t c);
    if (a > b) return FLAG_GT;
    else if (a < b) return FLAG_LT;
    else return c;
  endfunction

  assign pair     = pair_of(vec);
  assign tx       = pattern(vec, pair[1]);
  assign ty       = pattern(vec, pair[0]);
  assign tcin     = cin_of(vec);
  assign expv     = gran_ref(tx, ty, tcin);
  assign mismatch = !retired && (tout != expv);
  assign wrap     = !retired && !mismatch && (vec == VW'(NVEC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      byp     <= BW'(NP - 1);
      vec     <= '0;
      retired <= 1'b0;
    end else if (!retired) begin
      if (mismatch) begin
        retired <= 1'b1;
      end else if (wrap) begin
        vec <= '0;
        byp <= (byp == '0) ? BW'(NP - 1) : byp - 1'b1;
      end else begin
        vec <= vec + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cmp_repair_top.sv
module cmp_repair_top
  import cmp_repair_pkg::*;
#(
  parameter  int WIDTH = 64,
  parameter  int GRAN  = 8,
  localparam int NG    = WIDTH / GRAN,
  localparam int NP    = NG + 1,
  localparam int BW    = $clog2(NP)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic [NP-1:0]    defect_inj,
  output logic             eq_o,
  output logic             gt_o,
  output logic             lt_o
);

  logic [NP*GRAN-1:0] gx, gy, gx_f;
  cflag_t [NP-1:0]    gcin, gcout;
  cflag_t             fin, tout, tcin;
  logic [GRAN-1:0]    tx, ty;
  logic [BW-1:0]      byp_idx;
  logic               tst_mismatch, vec_wrap, retired;

  cmp_test_seq #(.GRAN(GRAN), .NP(NP)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .tout     (tout),
    .byp      (byp_idx),
    .tx       (tx),
    .ty       (ty),
    .tcin     (tcin),
    .mismatch (tst_mismatch),
    .wrap     (vec_wrap),
    .retired  (retired)
  );

  cmp_steer #(.GRAN(GRAN), .NG(NG)) u_steer (
    .x     (x_i),
    .y     (y_i),
    .byp   (byp_idx),
    .tx    (tx),
    .ty    (ty),
    .tcin  (tcin),
    .gcout (gcout),
    .gx    (gx),
    .gy    (gy),
    .gcin  (gcin),
    .fin   (fin),
    .tout  (tout)
  );

  // defect model: lowest x line of a physical granule stuck at 1
  always_comb begin
    gx_f = gx;
    for (int p = 0; p < NP; p++) begin
      gx_f[p*GRAN] = gx[p*GRAN] | defect_inj[p];
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_gran
    cmp_gran #(.GRAN(GRAN)) u_gran (
      .xa   (gx_f[p*GRAN +: GRAN]),
      .ya   (gy[p*GRAN +: GRAN]),
      .cin  (gcin[p]),
      .cout (gcout[p])
    );
  end

  assign eq_o = fin.eq;
  assign gt_o = fin.gt;
  assign lt_o = fin.lt;

endmodule

// File: rtl/cmp_repair_chk.sv
module cmp_repair_chk #(
  parameter int WIDTH = 64,
  parameter int NP    = 9,
  parameter int BW    = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] x_i,
  input logic [WIDTH-1:0] y_i,
  input logic [NP-1:0]    defect_inj,
  input logic             eq_o,
  input logic             gt_o,
  input logic             lt_o,
  input logic [BW-1:0]    byp_idx,
  input logic             vec_wrap,
  input logic             retired,
  input logic             tst_mismatch
);

  // R2
  one_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({eq_o, gt_o, lt_o}) == 1);

  // R1
  clean_order_chk: assert property (@(posedge clk) disable iff (rst)
    (defect_inj == '0) |-> ((gt_o == (x_i > y_i)) && (lt_o == (x_i < y_i))));

  // R8
  clean_equal_chk: assert property (@(posedge clk) disable iff (rst)
    ((defect_inj == '0) && (x_i == y_i)) |-> eq_o);

  // R3
  bypass_range_chk: assert property (@(posedge clk) disable iff (rst)
    byp_idx < BW'(NP));

  // R4
  move_on_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(byp_idx) |-> $past(vec_wrap));

  // R6
  detect_retire_chk: assert property (@(posedge clk) disable iff (rst)
    tst_mismatch |=> retired);

  // R7
  retired_hold_chk: assert property (@(posedge clk) disable iff (rst)
    retired |=> (retired && $stable(byp_idx)));

endmodule

bind cmp_repair_top cmp_repair_chk #(.WIDTH(WIDTH), .NP(NP), .BW(BW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .x_i          (x_i),
  .y_i          (y_i),
  .defect_inj   (defect_inj),
  .eq_o         (eq_o),
  .gt_o         (gt_o),
  .lt_o         (lt_o),
  .byp_idx      (byp_idx),
  .vec_wrap     (vec_wrap),
  .retired      (retired),
  .tst_mismatch (tst_mismatch)
);

// File: tb/cmp_repair_top_test.sv
module cmp_repair_top_test;

  localparam int W  = 64;
  localparam int G  = 8;
  localparam int NP = W / G + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  x = '0, y = '0;
  logic [NP-1:0] inj = '0;
  logic          eq, gt, lt;
  int            total = 0;
  int            fails = 0;

  always #2 clk = ~clk;

  cmp_repair_top #(.WIDTH(W), .GRAN(G)) uut (
    .clk(clk), .rst(rst), .x_i(x), .y_i(y), .defect_inj(inj),
    .eq_o(eq), .gt_o(gt), .lt_o(lt)
  );

  task automatic restart(input logic [NP-1:0] d);
    @(negedge clk);
    inj = d;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // apply on the falling edge, sample 1 ns later; exp = {eq,gt,lt}
  task automatic expect3(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [2:0] exp);
    @(negedge clk);
    x = a;
    y = b;
    #1;
    total++;
    if ({eq, gt, lt} !== exp) begin
      fails++;
      $display("FAIL %s: x=%h y=%h got eq/gt/lt=%b expected %b", req, a, b, {eq, gt, lt}, exp);
    end
  endtask

  task automatic cmp_ok(input string req, input logic [W-1:0] a, input logic [W-1:0] b);
    expect3(req, a, b, {a == b, a > b, a < b});
  endtask

  function automatic logic [W-1:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  task automatic random_burst(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      logic [W-1:0] a;
      a = rnd64();
      if (i % 2 == 0) cmp_ok(req, a, a ^ (64'd1 << ($urandom % W)));
      else cmp_ok(req, a, rnd64());
    end
  endtask

  task automatic t_reset();
    restart('0);
    expect3("R3", '0, '0, 3'b100);
    expect3("R8", '1, '1, 3'b100);
  endtask

  task automatic t_patterns();
    cmp_ok("R1", 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF);
    cmp_ok("R1", 64'h0000_0000_0000_0001, 64'h0);
    cmp_ok("R1", 64'h0, 64'h0000_0000_0000_0001);
    cmp_ok("R1", 64'h0000_0000_0000_0100, 64'h0000_0000_0000_00FF);
    cmp_ok("R1", 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0100);
    cmp_ok("R1", '1, '0);
    cmp_ok("R2", 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF1);
    cmp_ok("R8", 64'hA5A5_A5A5_5A5A_5A5A, 64'hA5A5_A5A5_5A5A_5A5A);
  endtask

  // two full rotations with no defect, sampling every few cycles
  task automatic t_rotation();
    for (int i = 0; i < 300; i++) begin
      random_burst("R4", 1);
      idle(5);
    end
  endtask

  task automatic t_spare_defect();
    restart(NP'(1) << (NP - 1));
    idle(50);
    expect3("R5", '0, 64'h1, 3'b001);
    random_burst("R5", 20);
  endtask

  task automatic t_active_defect();
    restart(NP'(1) << 3);
    expect3("R9", '0, 64'h1 << 24, 3'b100);
    idle(1200);
    expect3("R6", '0, 64'h1 << 24, 3'b001);
    random_burst("R6", 20);
    idle(3000);
    expect3("R7", '0, 64'h1 << 24, 3'b001);
    random_burst("R7", 20);
  endtask

  task automatic t_seed_defect();
    restart(NP'(1));
    expect3("R9", '0, 64'h1, 3'b100);
    idle(1200);
    expect3("R10", '0, 64'h1, 3'b001);
    cmp_ok("R10", 64'h1, 64'h0);
    random_burst("R10", 20);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    total++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    t_reset();
    t_patterns();
    t_rotation();
    t_spare_defect();
    t_active_defect();
    t_seed_defect();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule